// File: doc/BRIEF.md
# Reloadable Countdown Tick Timer

This block is a periodic tick source built around a 24-bit down counter that runs on the core clock. Software programs a reload value `n`, clears the counter, and sets the enable bit. The counter then walks `n, n-1, ... 1, 0` and loads `n` again, so one full turn takes `n+1` clocks. Each time the count steps from one to zero, a sticky status flag is set and, if the interrupt enable is on, a one-cycle tick pulse is raised on the interrupt output.

Three registers sit behind a plain read/write port: a control/status word, the reload value and the current value. Reading the control/status word returns the flag and clears it. Any write to the current-value register forces the count to zero and drops the flag, whatever data is written. A separate pend input lets software raise a tick pulse without the counter.

Top module: `tick_timer`

## Requirements
- R1: While the enable bit (control bit 0) is set and the count is nonzero, the count falls by exactly one per clock. While it is clear, the count holds.
- R2: When enabled with the count at zero, the next clock loads the reload value. With reload `n` the sequence is `n, n-1, ..., 0, n, ...`, which has a period of `n+1` clocks.
- R3: A step of the count from one to zero sets the count flag. The flag reads at bit 16 of the control/status register (select 0) and stays set until it is cleared.
- R4: A read of the control/status register (`rdEn` with select 0) returns the flag in that same cycle and clears it at the next clock edge.
- R5: Any write to the current-value register (select 2) sets the count to zero and clears the flag at the next edge. This takes priority over counting.
- R6: With the interrupt-enable bit (control bit 1) set, `tickIrq` is high for the one cycle that follows each step from one to zero. With the bit clear, the counter raises no pulse.
- R7: A high cycle on `pendIn` makes `tickIrq` high in the following cycle, whether or not the counter is enabled.
- R8: With reload zero, the enabled count stays at zero and produces no flag and no interrupt.
- R9: The reload (select 1) and current (select 2) registers keep only bits 23:0, and their bits 31:24 read as zero. The control register stores bits 0, 1 and 2 (bit 2 is the clock-source bit, which has no effect because only the core clock is used). Every other control bit except the flag reads as zero, and unused selects read as zero.
- R10: After reset, all registers read zero and `tickIrq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regSel | input | 2 | Register select: 0 control/status, 1 reload, 2 current |
| wrEn | input | 1 | Write strobe for the selected register |
| rdEn | input | 1 | Read strobe; needed only for the clear-on-read of the status register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data of the selected register, combinational |
| pendIn | input | 1 | Software tick request |
| tickIrq | output | 1 | One-cycle tick interrupt pulse |

## Verification
Read data is combinational, so a register write shows up in the next cycle. The count, the flag and `tickIrq` all change on the clock edge that follows their cause. Because enable is itself a register, the counter only starts moving on the edge after the enabling write.

The bench drives inputs on the falling edge and samples on the next falling edge. It numbers the rising edges after the enabling write as `k`. It expects the count to be 0 at `k=0` and `n-((k-1) mod (n+1))` after that, with a pulse exactly where that value is zero and `k>0`. The sweep runs `n` from 0 to 12, with the interrupt enable switched off for some values of `n`.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int SEL_W = 2;
  localparam logic [SEL_W-1:0] SEL_CTRL   = 2'd0;
  localparam logic [SEL_W-1:0] SEL_RELOAD = 2'd1;
  localparam logic [SEL_W-1:0] SEL_CUR    = 2'd2;

  // bit positions inside the control/status word
  localparam int EN_BIT   = 0;
  localparam int IRQ_BIT  = 1;
  localparam int SRC_BIT  = 2;
  localparam int FLAG_BIT = 16;

  typedef struct packed {
    logic run;      // counter enabled this cycle
    logic clrCnt;   // write to current-value register
    logic clrFlag;  // status register being read
  } tickStrobe_t;
endpackage

// File: rtl/tick_ctrl.sv
module tick_ctrl
  import tick_timer_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [SEL_W-1:0]     regSel,
  input  logic                 wrEn,
  input  logic                 rdEn,
  input  logic [DATA_W-1:0]    wrData,
  output tickStrobe_t          strobes,
  output logic [CNT_W-1:0]     reloadVal,
  output logic                 enBit,
  output logic                 irqEnBit,
  output logic                 srcBit
);
  logic ctrlWr;
  logic reloadWr;

  assign ctrlWr   = wrEn && (regSel == SEL_CTRL);
  assign reloadWr = wrEn && (regSel == SEL_RELOAD);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enBit     <= 1'b0;
      irqEnBit  <= 1'b0;
      srcBit    <= 1'b0;
      reloadVal <= '0;
    end else begin
      if (ctrlWr) begin
        enBit    <= wrData[EN_BIT];
        irqEnBit <= wrData[IRQ_BIT];
        srcBit   <= wrData[SRC_BIT];
      end
      if (reloadWr) reloadVal <= wrData[CNT_W-1:0];
    end
  end

  always_comb begin
    strobes.run     = enBit;
    strobes.clrCnt  = wrEn && (regSel == SEL_CUR);
    strobes.clrFlag = rdEn && (regSel == SEL_CTRL);
  end
endmodule

// File: rtl/tick_dp.sv
module tick_dp
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  tickStrobe_t      strobes,
  input  logic             irqEn,
  input  logic             pendIn,
  input  logic [CNT_W-1:0] reloadVal,
  output logic [CNT_W-1:0] curVal,
  output logic             flag,
  output logic             tickIrq
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic hitZero;
  assign hitZero = strobes.run && !strobes.clrCnt && (curVal == ONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curVal  <= '0;
      flag    <= 1'b0;
      tickIrq <= 1'b0;
    end else begin
      if (strobes.clrCnt)      curVal <= '0;
      else if (strobes.run)    curVal <= (curVal == '0) ? reloadVal : curVal - ONE;

      if (strobes.clrCnt)       flag <= 1'b0;
      else if (hitZero)         flag <= 1'b1;
      else if (strobes.clrFlag) flag <= 1'b0;

      tickIrq <= (hitZero && irqEn) || pendIn;
    end
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regSel,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              pendIn,
  output logic              tickIrq
);
  tickStrobe_t      strobes;
  logic [CNT_W-1:0] reloadVal;
  logic [CNT_W-1:0] curVal;
  logic             enBit;
  logic             irqEnBit;
  logic             srcBit;
  logic             flag;
  logic             curWr;

  assign curWr = strobes.clrCnt;

  tick_ctrl #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .strobes(strobes), .reloadVal(reloadVal),
    .enBit(enBit), .irqEnBit(irqEnBit), .srcBit(srcBit)
  );

  tick_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .irqEn(irqEnBit),
    .pendIn(pendIn), .reloadVal(reloadVal), .curVal(curVal),
    .flag(flag), .tickIrq(tickIrq)
  );

  always_comb begin
    rdData = '0;
    unique case (regSel)
      SEL_CTRL: begin
        rdData[EN_BIT]   = enBit;
        rdData[IRQ_BIT]  = irqEnBit;
        rdData[SRC_BIT]  = srcBit;
        rdData[FLAG_BIT] = flag;
      end
      SEL_RELOAD: rdData[CNT_W-1:0] = reloadVal;
      SEL_CUR:    rdData[CNT_W-1:0] = curVal;
      default:    rdData = '0;
    endcase
  end
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rstN,
  input logic             enBit,
  input logic             irqEnBit,
  input logic             curWr,
  input logic [CNT_W-1:0] curVal,
  input logic [CNT_W-1:0] reloadVal,
  input logic             flag,
  input logic             pendIn,
  input logic             tickIrq
);
  // R1
  count_dec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enBit && !curWr && curVal != '0) |=> curVal == $past(curVal) - CNT_W'(1));
  // R1
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!enBit && !curWr) |=> $stable(curVal));
  // R2
  count_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enBit && !curWr && curVal == '0) |=> curVal == $past(reloadVal));
  // R3
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enBit && !curWr && curVal == CNT_W'(1)) |=> flag);
  // R5
  cur_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    curWr |=> (curVal == '0) && !flag);
  // R6
  irq_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enBit && irqEnBit && !curWr && curVal == CNT_W'(1)) |=> tickIrq);
  // R7
  irq_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
    pendIn |=> tickIrq);
  // R8
  zero_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enBit && !pendIn && curVal == '0 && reloadVal == '0) |=> !tickIrq);
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .enBit(enBit), .irqEnBit(irqEnBit),
  .curWr(curWr), .curVal(curVal), .reloadVal(reloadVal), .flag(flag),
  .pendIn(pendIn), .tickIrq(tickIrq)
);

// File: tb/tick_timer_bench.sv
module tick_timer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  regSel = 2'd0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        pendIn = 1'b0;
  logic        tickIrq;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  tick_timer u_tick_timer (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .pendIn(pendIn), .tickIrq(tickIrq)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      total = total + 1;
      bad = bad + 1;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one bus write, ends at the next falling edge
  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    regSel = sel; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  function automatic logic [31:0] expCount(input int n, input int k);
    if (k == 0) return 32'd0;
    return 32'(n - ((k - 1) % (n + 1)));
  endfunction

  initial begin
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    regSel = 2'd0; #1 check("R10 ctrl", rdData, 32'h0);
    regSel = 2'd1; #1 check("R10 reload", rdData, 32'h0);
    regSel = 2'd2; #1 check("R10 cur", rdData, 32'h0);
    check("R10 irq", {31'b0, tickIrq}, 32'h0);

    // R9 field widths
    wr(2'd1, 32'hFFFF_FFFF);
    regSel = 2'd1; #1 check("R9 reload upper", rdData, 32'h00FF_FFFF);
    wr(2'd2, 32'h1234_5678);
    regSel = 2'd2; #1 check("R9 cur", rdData, 32'h0);
    wr(2'd0, 32'hFFFF_FFFF);
    regSel = 2'd0; #1 check("R9 ctrl bits", rdData, 32'h0000_0007);
    wr(2'd0, 32'h0);
    regSel = 2'd3; #1 check("R9 unused select", rdData, 32'h0);

    // R7 pend with counter disabled
    @(negedge clk);
    pendIn = 1'b1;
    @(negedge clk);
    pendIn = 1'b0;
    check("R7 pend pulse", {31'b0, tickIrq}, 32'h1);
    @(negedge clk);
    check("R7 pend one cycle", {31'b0, tickIrq}, 32'h0);

    // R1 R2 R3 R4 R6 R8 sweep over reload values
    for (int n = 0; n <= 12; n++) begin
      automatic bit irqOn = (n % 3) != 2;
      automatic int kMax = 2 * (n + 1) + 1;
      wr(2'd0, 32'h0);
      wr(2'd1, 32'(n));
      wr(2'd2, 32'hABCD_EF12);
      wr(2'd0, irqOn ? 32'h3 : 32'h1);
      regSel = 2'd2;
      for (int k = 0; k <= kMax; k++) begin
        automatic logic [31:0] e = expCount(n, k);
        #1;
        check("R1 R2 R8 count", rdData, e);
        check("R6 R8 tick", {31'b0, tickIrq},
              {31'b0, (irqOn && n > 0 && k > 0 && e == 0)});
        @(negedge clk);
      end
      wr(2'd0, 32'h0);
      // R3 R4 sticky flag, cleared by read
      regSel = 2'd0; rdEn = 1'b1; #1;
      check("R3 flag", rdData, (n > 0 && kMax + 1 >= n + 1) ? 32'h0001_0000 : 32'h0);
      @(negedge clk);
      rdEn = 1'b0; #1;
      check("R4 flag cleared", rdData, 32'h0);
    end

    // R5 current write while running
    wr(2'd1, 32'd4);
    wr(2'd2, 32'h0);
    wr(2'd0, 32'h1);
    repeat (7) @(negedge clk);
    wr(2'd2, 32'hFFFF_FFFF);
    regSel = 2'd2; #1 check("R5 count zeroed", rdData, 32'h0);
    regSel = 2'd0; #1 check("R5 flag cleared", rdData, 32'h0000_0001);
    wr(2'd0, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule